// File: doc/BRIEF.md
# Bus-Width Matching Adapter with Selectable Lane Order

This block sits between a fixed 36-bit wide side (side A) and a side B whose width is configured as 36, 18 or 9 bits. Data is organised in four 9-bit lanes. Going from A to B, each 36-bit long word is cut into one, two or four narrow transfers. Going from B to A, narrow transfers are gathered into a 36-bit long word, which is released only once it is complete. Storage, flags and mailboxes are not part of this block. It is meant to be placed between the wide and narrow halves of a bidirectional queue.

Both the width of side B and the lane order are sampled from two plain pins while master reset is held low. The value present on the last clock edge before reset is released is kept, and it stays fixed until the next master reset. The order is either most-significant piece first (pin high) or least-significant piece first (pin low). The data moves on four valid/ready streams: `a_in` and `b_out` for the split direction, and `b_in` and `a_out` for the pack direction. A transfer happens on a rising clock edge where valid and ready are both high. A producer holding valid with ready low must keep its data unchanged. A consumer may drop ready at any time. The block never advances a split or a pack while the side downstream of it refuses data. A partial reset drops any half-split or half-packed word and keeps the configuration.

Top module: `bus_width_adapter`

## Requirements
- R1: While `mrst_n` is low, `size_sel` is sampled on each clock edge. Code 1 selects 18 bits (two pieces per long word), code 2 selects 9 bits (four pieces), and codes 0 and 3 select 36 bits (one piece). `big_sel` high selects most-significant-first order.
- R2: Once `mrst_n` is high, changes on `size_sel` and `big_sel` have no effect on the width or order used, until the next master reset.
- R3: In most-significant-first order, the pieces of a long word leave on `b_out_data` starting with the highest-numbered piece. Piece i of width W is bits [i*W+W-1 : i*W] of the long word. Each piece appears on the low W bits and the upper bits are zero.
- R4: In least-significant-first order, the pieces leave starting with piece 0 and going up.
- R5: On `b_in`, only the low W bits of each transfer are used. They fill the pieces of the packed word in the same order as R3/R4. `a_out_valid` rises only after the last piece of the word has been accepted.
- R6: While `b_out_valid` (or `a_out_valid`) is high and the matching ready is low, the valid stays high and the data stays unchanged on the next cycle. A piece is consumed only on a cycle where ready is high.
- R7: `a_in_ready` is high when no long word is being split, or when the last piece is leaving on that cycle. `b_in_ready` is high unless a packed word is waiting with `a_out_ready` low.
- R8: A cycle with `prst_n` low empties both directions, so that `b_out_valid` and `a_out_valid` are low afterwards. The captured configuration is kept.
- R9: After master reset, both output valids are low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, synchronous; configuration is sampled while it is low |
| prst_n | input | 1 | Partial reset, active low, synchronous; clears partial-word state only |
| size_sel | input | 2 | Side-B width code (1: 18 bits, 2: 9 bits, otherwise 36 bits) |
| big_sel | input | 1 | Lane order: 1 most-significant first, 0 least-significant first |
| a_in_valid | input | 1 | Long word offered from side A |
| a_in_ready | output | 1 | Adapter accepts the long word |
| a_in_data | input | 36 | Long word from side A |
| b_out_valid | output | 1 | Narrow piece offered to side B |
| b_out_ready | input | 1 | Side B accepts the piece |
| b_out_data | output | 36 | Piece on the low bits, upper bits zero |
| b_in_valid | input | 1 | Narrow piece offered from side B |
| b_in_ready | output | 1 | Adapter accepts the piece |
| b_in_data | input | 36 | Piece on the low bits; upper bits ignored |
| a_out_valid | output | 1 | Packed long word offered to side A |
| a_out_ready | input | 1 | Side A accepts the long word |
| a_out_data | output | 36 | Packed long word |

## Verification
Each of the eight combinations of width code and order is exercised with random long words and random pieces. The upper bits of `b_in_data` are random, so a design that lets them leak into a packed word is caught. Ready is toggled at random on both downstream sides. This separates a block that holds its pieces under back-pressure from one that skips or repeats them. It also separates the exact ready rules from looser ones. A single word sent right after reset, and sent again after the pins have been changed, tells the sampled width apart from the live pin value. A partial reset in the middle of traffic shows whether the half-built words are dropped.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {BW_FULL = 2'd0, BW_HALF = 2'd1, BW_LANE = 2'd2} bw_e;

  function automatic bw_e decode_bw(input logic [1:0] code);
    case (code)
      2'd1:    return BW_HALF;
      2'd2:    return BW_LANE;
      default: return BW_FULL;
    endcase
  endfunction

  function automatic logic [1:0] last_beat(input bw_e bw);
    case (bw)
      BW_HALF: return 2'd1;
      BW_LANE: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] beat_slot(input bw_e bw, input logic big, input logic [1:0] cnt);
    return big ? last_beat(bw) - cnt : cnt;
  endfunction
endpackage

// File: rtl/bwa_cfg_latch.sv
module bwa_cfg_latch
  import bwa_pkg::*;
(
  input  logic       clk,
  input  logic       mrst_n,
  input  logic [1:0] size_sel,
  input  logic       big_sel,
  output bw_e        bw,
  output logic       big
);
  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      bw  <= decode_bw(size_sel);
      big <= big_sel;
    end
  end
endmodule

// File: rtl/bwa_splitter.sv
module bwa_splitter
  import bwa_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              clr,
  input  bw_e               bw,
  input  logic              big,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LANES*LANE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LANES*LANE_W-1:0] out_data
);
  localparam int DW = LANES * LANE_W;
  localparam int HW = 2 * LANE_W;

  logic [DW-1:0] word_q;
  logic [1:0]    cnt_q;
  logic          full_q;
  logic          last;
  logic          take_out;
  logic          take_in;
  int            slot;

  assign last      = (cnt_q == last_beat(bw));
  assign out_valid = full_q;
  assign in_ready  = !full_q || (out_ready && last);
  assign take_out  = full_q && out_ready;
  assign take_in   = in_valid && in_ready;

  always_comb begin
    slot     = int'(beat_slot(bw, big, cnt_q));
    out_data = '0;
    case (bw)
      BW_HALF: out_data[HW-1:0]     = word_q[slot*HW +: HW];
      BW_LANE: out_data[LANE_W-1:0] = word_q[slot*LANE_W +: LANE_W];
      default: out_data             = word_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      full_q <= 1'b0;
      cnt_q  <= '0;
      word_q <= '0;
    end else begin
      if (take_out) begin
        if (last) begin
          cnt_q  <= '0;
          full_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 2'd1;
        end
      end
      if (take_in) begin
        word_q <= in_data;
        full_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bwa_packer.sv
module bwa_packer
  import bwa_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              clr,
  input  bw_e               bw,
  input  logic              big,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LANES*LANE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LANES*LANE_W-1:0] out_data
);
  localparam int DW = LANES * LANE_W;
  localparam int HW = 2 * LANE_W;

  logic [DW-1:0] acc_q;
  logic [1:0]    cnt_q;
  logic          full_q;
  logic          last;
  logic          take_in;
  int            slot;

  assign last      = (cnt_q == last_beat(bw));
  assign out_valid = full_q;
  assign out_data  = acc_q;
  assign in_ready  = !full_q || out_ready;
  assign take_in   = in_valid && in_ready;
  assign slot      = int'(beat_slot(bw, big, cnt_q));

  always_ff @(posedge clk) begin
    if (clr) begin
      full_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else begin
      if (full_q && out_ready) full_q <= 1'b0;
      if (take_in) begin
        case (bw)
          BW_HALF: acc_q[slot*HW +: HW]         <= in_data[HW-1:0];
          BW_LANE: acc_q[slot*LANE_W +: LANE_W] <= in_data[LANE_W-1:0];
          default: acc_q                        <= in_data;
        endcase
        if (last) begin
          cnt_q  <= '0;
          full_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwa_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    mrst_n,
  input  logic                    prst_n,
  input  logic [1:0]              size_sel,
  input  logic                    big_sel,
  input  logic                    a_in_valid,
  output logic                    a_in_ready,
  input  logic [LANES*LANE_W-1:0] a_in_data,
  output logic                    b_out_valid,
  input  logic                    b_out_ready,
  output logic [LANES*LANE_W-1:0] b_out_data,
  input  logic                    b_in_valid,
  output logic                    b_in_ready,
  input  logic [LANES*LANE_W-1:0] b_in_data,
  output logic                    a_out_valid,
  input  logic                    a_out_ready,
  output logic [LANES*LANE_W-1:0] a_out_data
);
  bw_e  cfg_bw;
  logic cfg_big;
  logic clr;

  assign clr = !mrst_n || !prst_n;

  bwa_cfg_latch u_cfg (
    .clk(clk), .mrst_n(mrst_n), .size_sel(size_sel), .big_sel(big_sel),
    .bw(cfg_bw), .big(cfg_big)
  );

  bwa_splitter #(.LANE_W(LANE_W)) u_split (
    .clk(clk), .clr(clr), .bw(cfg_bw), .big(cfg_big),
    .in_valid(a_in_valid), .in_ready(a_in_ready), .in_data(a_in_data),
    .out_valid(b_out_valid), .out_ready(b_out_ready), .out_data(b_out_data)
  );

  bwa_packer #(.LANE_W(LANE_W)) u_pack (
    .clk(clk), .clr(clr), .bw(cfg_bw), .big(cfg_big),
    .in_valid(b_in_valid), .in_ready(b_in_ready), .in_data(b_in_data),
    .out_valid(a_out_valid), .out_ready(a_out_ready), .out_data(a_out_data)
  );
endmodule

// File: rtl/bwa_checker.sv
module bwa_checker
  import bwa_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    mrst_n,
  input logic                    prst_n,
  input bw_e                     cfg_bw,
  input logic                    cfg_big,
  input logic                    b_out_valid,
  input logic                    b_out_ready,
  input logic [LANES*LANE_W-1:0] b_out_data,
  input logic                    a_out_valid,
  input logic                    a_out_ready,
  input logic [LANES*LANE_W-1:0] a_out_data
);
  localparam int DW = LANES * LANE_W;

  assert_cfg_fixed_R2: assert property (@(posedge clk) disable iff (!mrst_n)
    $past(mrst_n) |-> ($stable(cfg_bw) && $stable(cfg_big)));

  assert_narrow_zero_R3: assert property (@(posedge clk) disable iff (!mrst_n)
    (b_out_valid && cfg_bw == BW_LANE) |-> (b_out_data[DW-1:LANE_W] == '0));

  assert_hold_split_R6: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    (b_out_valid && !b_out_ready) |=> (b_out_valid && $stable(b_out_data)));

  assert_hold_pack_R6: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    (a_out_valid && !a_out_ready) |=> (a_out_valid && $stable(a_out_data)));

  assert_part_clear_R8: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> (!b_out_valid && !a_out_valid));

  assert_master_clear_R9: assert property (@(posedge clk) disable iff (!prst_n)
    !mrst_n |=> (!b_out_valid && !a_out_valid));
endmodule

bind bus_width_adapter bwa_checker #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .cfg_bw(cfg_bw), .cfg_big(cfg_big),
  .b_out_valid(b_out_valid), .b_out_ready(b_out_ready), .b_out_data(b_out_data),
  .a_out_valid(a_out_valid), .a_out_ready(a_out_ready), .a_out_data(a_out_data)
);

// File: tb/bus_width_adapter_tb.sv
`timescale 1ns/1ps
module bus_width_adapter_tb;
  logic        clk = 1'b0;
  logic        mrst_n = 1'b0, prst_n = 1'b1;
  logic [1:0]  size_sel = 2'd0;
  logic        big_sel = 1'b0;
  logic        a_in_valid = 1'b0, b_out_ready = 1'b0, b_in_valid = 1'b0, a_out_ready = 1'b0;
  logic [35:0] a_in_data = '0, b_in_data = '0;
  logic        a_in_ready, b_out_valid, b_in_ready, a_out_valid;
  logic [35:0] b_out_data, a_out_data;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  bus_width_adapter #(.LANE_W(9)) u_dut (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .size_sel(size_sel), .big_sel(big_sel),
    .a_in_valid(a_in_valid), .a_in_ready(a_in_ready), .a_in_data(a_in_data),
    .b_out_valid(b_out_valid), .b_out_ready(b_out_ready), .b_out_data(b_out_data),
    .b_in_valid(b_in_valid), .b_in_ready(b_in_ready), .b_in_data(b_in_data),
    .a_out_valid(a_out_valid), .a_out_ready(a_out_ready), .a_out_data(a_out_data)
  );

  always #4 clk = ~clk;

  // reference model state
  int          m_n = 1;
  bit          m_big = 0;
  logic [35:0] sq[$];
  logic [35:0] pk[$];
  bit          wfull = 0;
  logic [35:0] wdata = '0;
  int          obs = 0;
  string       ovr = "";

  function automatic int beats_of(input logic [1:0] code);
    return (code == 2'd1) ? 2 : (code == 2'd2) ? 4 : 1;
  endfunction

  function automatic logic [35:0] piece(input logic [35:0] w, input int n, input bit big, input int k);
    int idx = big ? n - 1 - k : k;
    int wd = 36 / n;
    logic [63:0] m = (64'h1 << wd) - 64'h1;
    return 36'(({28'h0, w} >> (idx * wd)) & m);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", (ovr != "") ? ovr : tag, what, act, exp);
    end
  endtask

  task automatic step(input bit av, input logic [35:0] ad, input bit bor,
                      input bit bv, input logic [35:0] bd, input bit aor, input bit prst);
    bit e_bov, e_air, e_bir;
    @(negedge clk);
    a_in_valid = av; a_in_data = ad; b_out_ready = bor;
    b_in_valid = bv; b_in_data = bd; a_out_ready = aor; prst_n = prst;
    #1;
    e_bov = sq.size() > 0;
    e_air = (sq.size() == 0) || (sq.size() == 1 && bor);
    e_bir = !wfull || aor;
    chk(b_out_valid == e_bov, "R6", "b_out_valid", 36'(b_out_valid), 36'(e_bov));
    if (e_bov) chk(b_out_data == sq[0], m_big ? "R3" : "R4", "b_out_data", b_out_data, sq[0]);
    chk(a_in_ready == e_air, "R7", "a_in_ready", 36'(a_in_ready), 36'(e_air));
    chk(a_out_valid == wfull, "R5", "a_out_valid", 36'(a_out_valid), 36'(wfull));
    if (wfull) chk(a_out_data == wdata, "R5", "a_out_data", a_out_data, wdata);
    chk(b_in_ready == e_bir, "R7", "b_in_ready", 36'(b_in_ready), 36'(e_bir));
    if (b_out_valid && bor) obs++;
    if (!prst) begin
      sq.delete(); pk.delete(); wfull = 0;
    end else begin
      if (e_bov && bor) void'(sq.pop_front());
      if (av && e_air) for (int k = 0; k < m_n; k++) sq.push_back(piece(ad, m_n, m_big, k));
      if (wfull && aor) wfull = 0;
      if (bv && e_bir) begin
        pk.push_back(piece(bd, m_n, 1'b0, 0));
        if (pk.size() == m_n) begin
          wdata = '0;
          for (int k = 0; k < m_n; k++) begin
            int idx = m_big ? m_n - 1 - k : k;
            wdata = wdata | 36'(64'(pk[k]) << (idx * (36 / m_n)));
          end
          wfull = 1; pk.delete();
        end
      end
    end
  endtask

  task automatic master_reset(input logic [1:0] code, input bit big);
    @(negedge clk);
    mrst_n = 0; size_sel = code; big_sel = big;
    a_in_valid = 0; b_in_valid = 0; b_out_ready = 0; a_out_ready = 0;
    repeat (3) @(negedge clk);
    mrst_n = 1;
    m_n = beats_of(code); m_big = big;
    sq.delete(); pk.delete(); wfull = 0;
  endtask

  task automatic count_test(input string tag);
    repeat (6) step(0, '0, 1, 0, '0, 1, 1);
    obs = 0;
    step(1, {$urandom, $urandom}, 1, 0, '0, 1, 1);
    repeat (5) step(0, '0, 1, 0, '0, 1, 1);
    chk(obs == m_n, tag, "pieces per long word", 36'(obs), 36'(m_n));
  endtask

  task automatic random_steps(input int cnt);
    for (int i = 0; i < cnt; i++)
      step($urandom_range(0, 3) != 0, {$urandom, $urandom}, $urandom_range(0, 9) < 7,
           $urandom_range(0, 3) != 0, {$urandom, $urandom}, $urandom_range(0, 9) < 7, 1);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      for (int b = 0; b < 2; b++) begin
        master_reset(2'(c), 1'(b));
        ovr = "R9";
        step(0, '0, 0, 0, '0, 0, 1);
        ovr = "";
        count_test("R1");
        size_sel = 2'(c + 1); big_sel = !1'(b);
        count_test("R2");
        random_steps(80);
        random_steps(5);
        step(0, '0, 0, 0, '0, 0, 0);
        ovr = "R8";
        step(0, '0, 0, 0, '0, 0, 1);
        ovr = "";
        random_steps(40);
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule